// File: doc/BRIEF.md
# Split-Port Core to Shared Memory Bus Bridge

This block lets a processor core that expects two separate memory ports (an instruction port and a data port, both answering reads in zero cycles) run over a single memory-mapped master port, where read data arrives one cycle after the request is accepted and the slave may stall any request with a wait signal. The bridge watches the address and strobe outputs that the core drives combinationally. For each core step it carries out the needed bus transfers one after another, keeps the returned words, and then pulses a one-cycle step enable. The core advances only on that pulse, so from the core's point of view every access completed with zero latency.

Each step begins with an instruction read. The fetched word goes to the core straight from the bus during the capture cycle, so the core can decode it and say in that same cycle whether it needs a data read, a data write or neither. A data read is captured in the same way. A data write is issued with every byte lane enabled. The step pulse follows. The core's run flag and result word pass through to the bridge outputs unchanged.

The bus side uses a plain stall rule. A request stays on the bus, with its address, strobe and write data unchanged, for as long as `bus_wait` is high. It completes at the first clock edge where `bus_wait` is low. The bridge never raises a read and a write strobe together, and it starts no transfer while reset is high.

Top module: `split_to_shared_bridge`

## Requirements
- R1: While `rst` is high, `bus_rd`, `bus_wr` and `core_step` are low in the same cycle. After `rst` falls, the first bus transfer is a read of `core_iaddr`.
- R2: Every step begins with a read of `core_iaddr`. A data read at `core_daddr` follows only when the core raises `core_dread` for the fetched word. A write follows only when it raises `core_dwrite`. Otherwise no data transfer takes place.
- R3: While `bus_wait` is high, an active request keeps its strobe, `bus_addr` and (for writes) `bus_wdata` unchanged into the next cycle.
- R4: Read data is taken from `bus_rdata` in the cycle after the clock edge at which the read was accepted (`bus_wait` low).
- R5: `core_step` is high for exactly one cycle per step and never in two consecutive cycles. With stall depth W on every transfer, the time from one step pulse to the next is W+3 cycles with no data access, 2W+5 cycles with a data read, and 2W+4 cycles with a write.
- R6: While `core_step` is high, `core_iword` equals memory at the instruction address. When a read was made, `core_drdata` equals memory at the data address.
- R7: A write puts `core_daddr` on `bus_addr` and `core_dwdata` on `bus_wdata`, with `bus_be` = 4'b1111. The write completes before the step pulse.
- R8: `bus_rd` and `bus_wr` are never high in the same cycle.
- R9: `active_out` equals `core_active` and `result_out` equals `core_result` in the same cycle.
- R10: Raising `rst` during a stalled transfer drops its strobe in that same cycle. After release, the bridge restarts with an instruction read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, may last several cycles |
| core_active | input | 1 | Run flag from the core |
| core_result | input | DATA_W | Result word from the core |
| core_iaddr | input | ADDR_W | Instruction address from the core |
| core_iword | output | DATA_W | Instruction word presented to the core |
| core_daddr | input | ADDR_W | Data address from the core |
| core_dread | input | 1 | Core requests a data read for this step |
| core_dwrite | input | 1 | Core requests a data write for this step |
| core_dwdata | input | DATA_W | Data to write |
| core_drdata | output | DATA_W | Data word presented to the core |
| core_step | output | 1 | One-cycle enable that lets the core advance |
| active_out | output | 1 | Forwarded run flag |
| result_out | output | DATA_W | Forwarded result word |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wait | input | 1 | Slave stall: request must be held |
| bus_wdata | output | DATA_W | Write data |
| bus_be | output | DATA_W/8 | Byte lane enables |
| bus_rdata | input | DATA_W | Read data, valid the cycle after acceptance |

## Verification
The bench builds the bridge with its default 32-bit address and data widths and drives it from a small stand-in core and a memory model whose stall depth is set per scenario (0, 1, 3 and 4 wait cycles). Sweeping the stall depth brings the exact step-to-step cycle counts of every step kind into reach, along with the hold-while-stalled rule on reads and writes. A reset raised during a stalled fetch exercises the abandon-and-restart path.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [2:0] {
    PH_FETCH      = 3'd0,
    PH_FETCH_TAKE = 3'd1,
    PH_LOAD       = 3'd2,
    PH_LOAD_TAKE  = 3'd3,
    PH_STORE      = 3'd4,
    PH_STEP       = 3'd5
  } phase_t;
endpackage

// File: rtl/bridge_seq.sv
module bridge_seq
  import bridge_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   bus_wait,
  input  logic   want_load,
  input  logic   want_store,
  output phase_t phase,
  output logic   rd_req,
  output logic   wr_req,
  output logic   take_instr,
  output logic   take_data,
  output logic   step_pulse
);
  phase_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_FETCH:      if (!bus_wait) ph_d = PH_FETCH_TAKE;
      PH_FETCH_TAKE: begin
        if (want_load)       ph_d = PH_LOAD;
        else if (want_store) ph_d = PH_STORE;
        else                 ph_d = PH_STEP;
      end
      PH_LOAD:       if (!bus_wait) ph_d = PH_LOAD_TAKE;
      PH_LOAD_TAKE:  ph_d = PH_STEP;
      PH_STORE:      if (!bus_wait) ph_d = PH_STEP;
      PH_STEP:       ph_d = PH_FETCH;
      default:       ph_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_FETCH;
    else     ph_q <= ph_d;
  end

  assign phase      = ph_q;
  assign rd_req     = !rst && (ph_q == PH_FETCH || ph_q == PH_LOAD);
  assign wr_req     = !rst && (ph_q == PH_STORE);
  assign take_instr = !rst && (ph_q == PH_FETCH_TAKE);
  assign take_data  = !rst && (ph_q == PH_LOAD_TAKE);
  assign step_pulse = !rst && (ph_q == PH_STEP);

  // R5: the enable never lasts two cycles
  p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
    step_pulse |=> !step_pulse);

  // R4: a captured data word is always followed by the step pulse
  p_take_then_step_r4: assert property (@(posedge clk) disable iff (rst)
    take_data |=> step_pulse);
endmodule

// File: rtl/bridge_hold.sv
module bridge_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bridge_route.sv
module bridge_route
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  phase_t              phase,
  input  logic [ADDR_W-1:0]   instr_addr,
  input  logic [ADDR_W-1:0]   data_addr,
  input  logic [DATA_W-1:0]   data_wdata,
  input  logic [DATA_W-1:0]   bus_rdata,
  input  logic [DATA_W-1:0]   instr_held,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   instr_word
);
  localparam int BE_W = DATA_W / 8;

  assign bus_addr   = (phase == PH_FETCH) ? instr_addr : data_addr;
  assign bus_wdata  = data_wdata;
  assign bus_be     = {BE_W{1'b1}};
  // live bus word during capture, so the core can decode it this cycle
  assign instr_word = (phase == PH_FETCH_TAKE) ? bus_rdata : instr_held;
endmodule

// File: rtl/split_to_shared_bridge.sv
module split_to_shared_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                core_active,
  input  logic [DATA_W-1:0]   core_result,
  input  logic [ADDR_W-1:0]   core_iaddr,
  output logic [DATA_W-1:0]   core_iword,
  input  logic [ADDR_W-1:0]   core_daddr,
  input  logic                core_dread,
  input  logic                core_dwrite,
  input  logic [DATA_W-1:0]   core_dwdata,
  output logic [DATA_W-1:0]   core_drdata,
  output logic                core_step,
  output logic                active_out,
  output logic [DATA_W-1:0]   result_out,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_wr,
  output logic                bus_rd,
  input  logic                bus_wait,
  output logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_rdata
);
  localparam int NUM_HOLD = 2;

  phase_t              phase;
  logic                take_instr, take_data;
  logic [NUM_HOLD-1:0] take;
  logic [DATA_W-1:0]   held [NUM_HOLD];

  bridge_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .bus_wait   (bus_wait),
    .want_load  (core_dread),
    .want_store (core_dwrite),
    .phase      (phase),
    .rd_req     (bus_rd),
    .wr_req     (bus_wr),
    .take_instr (take_instr),
    .take_data  (take_data),
    .step_pulse (core_step)
  );

  assign take = {take_data, take_instr};

  for (genvar g = 0; g < NUM_HOLD; g++) begin : g_hold
    bridge_hold #(.W(DATA_W)) u_hold (
      .clk  (clk),
      .rst  (rst),
      .load (take[g]),
      .d    (bus_rdata),
      .q    (held[g])
    );
  end

  bridge_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .phase      (phase),
    .instr_addr (core_iaddr),
    .data_addr  (core_daddr),
    .data_wdata (core_dwdata),
    .bus_rdata  (bus_rdata),
    .instr_held (held[0]),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_be     (bus_be),
    .instr_word (core_iword)
  );

  assign core_drdata = held[1];
  assign active_out  = core_active;
  assign result_out  = core_result;

  // R1: bus stays quiet throughout reset
  always @(posedge clk) begin
    if (rst) begin
      p_quiet_reset_r1: assert (!bus_rd && !bus_wr && !core_step)
        else $error("bus strobe or step during reset");
    end
  end

  // R3: stalled read held with the same address
  p_hold_read_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_wait) |=> (bus_rd && $stable(bus_addr)));

  // R3: stalled write held with the same address and data
  p_hold_write_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_wait) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

  // R8: never both strobes
  p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  // R7: a write is followed by the step pulse once accepted
  p_write_then_step_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_wait) |=> core_step);
endmodule

// File: tb/test_split_to_shared_bridge.sv
module test_split_to_shared_bridge;
  localparam int          AW   = 32;
  localparam int          DW   = 32;
  localparam logic [31:0] BASE = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          st_active = 1'b0;
  logic [DW-1:0] st_result = '0;
  logic [AW-1:0] iaddr, daddr, bus_addr;
  logic [DW-1:0] iword, dwdata, drdata, result_out, bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic          dread, dwrite, step, active_out, bus_wr, bus_rd, bus_wait;
  logic [3:0]    bus_be;

  split_to_shared_bridge #(.ADDR_W(AW), .DATA_W(DW)) i_split_to_shared_bridge (
    .clk(clk), .rst(rst),
    .core_active(st_active), .core_result(st_result),
    .core_iaddr(iaddr), .core_iword(iword),
    .core_daddr(daddr), .core_dread(dread), .core_dwrite(dwrite),
    .core_dwdata(dwdata), .core_drdata(drdata), .core_step(step),
    .active_out(active_out), .result_out(result_out),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wait(bus_wait),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata)
  );

  // stand-in core: op 01 = load from word[15:0], op 10 = store acc there
  logic [31:0] pc, acc;
  logic [1:0]  op;
  assign op     = iword[31:30];
  assign dread  = (op == 2'b01);
  assign dwrite = (op == 2'b10);
  assign daddr  = {16'h0, iword[15:0]};
  assign dwdata = acc;
  assign iaddr  = pc;
  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= BASE;
      acc <= '0;
    end else if (step) begin
      pc <= pc + 32'd4;
      if (dread) acc <= drdata;
    end
  end

  // memory model with programmable stall depth and one-cycle read latency
  logic [31:0] mem [0:255];
  int wait_n = 0;
  int cnt = 0;
  assign bus_wait = (bus_rd || bus_wr) && (cnt < wait_n);
  always @(posedge clk) begin
    if (rst) cnt <= 0;
    else if (bus_rd || bus_wr) begin
      if (cnt < wait_n) cnt <= cnt + 1;
      else begin
        cnt <= 0;
        if (bus_wr) mem[bus_addr[9:2]] <= bus_wdata;
        else        bus_rdata <= mem[bus_addr[9:2]];
      end
    end
  end

  // bus monitor
  int cyc = 0, nrd = 0, nwr = 0, nstep = 0;
  int bad_reset = 0, bad_both = 0, bad_hold = 0, bad_step2 = 0;
  logic [31:0] rd_log [16];
  int          step_at [16];
  logic [31:0] wr_addr_log = '0, wr_data_log = '0;
  logic [3:0]  wr_be_log = '0;
  logic        prev_wrd = 1'b0, prev_wwr = 1'b0, prev_step = 1'b0;
  logic [31:0] prev_addr = '0, prev_wdata = '0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst && (bus_rd || bus_wr)) bad_reset <= bad_reset + 1;
    if (bus_rd && bus_wr) bad_both <= bad_both + 1;
    if (!rst && prev_wrd && !(bus_rd && bus_addr == prev_addr)) bad_hold <= bad_hold + 1;
    if (!rst && prev_wwr && !(bus_wr && bus_addr == prev_addr && bus_wdata == prev_wdata))
      bad_hold <= bad_hold + 1;
    if (!rst && step && prev_step) bad_step2 <= bad_step2 + 1;
    prev_wrd   <= !rst && bus_rd && bus_wait;
    prev_wwr   <= !rst && bus_wr && bus_wait;
    prev_step  <= !rst && step;
    prev_addr  <= bus_addr;
    prev_wdata <= bus_wdata;
    if (rst) begin
      nrd <= 0; nwr <= 0; nstep <= 0;
    end else begin
      if (bus_rd && !bus_wait) begin
        if (nrd < 16) rd_log[nrd] <= bus_addr;
        nrd <= nrd + 1;
      end
      if (bus_wr && !bus_wait) begin
        wr_addr_log <= bus_addr;
        wr_data_log <= bus_wdata;
        wr_be_log   <= bus_be;
        nwr <= nwr + 1;
      end
      if (step) begin
        if (nstep < 16) step_at[nstep] <= cyc;
        nstep <= nstep + 1;
      end
    end
  end

  int errors = 0;
  int checks = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load_program();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[65]  = 32'h4000_0200;  // load from 0x200
    mem[66]  = 32'h8000_0204;  // store to 0x204
    mem[128] = 32'hCAFE_1234;
  endtask

  task automatic wait_steps(input int n);
    int lim = 0;
    while (nstep < n && lim < 5000) begin
      @(negedge clk);
      lim++;
    end
    chk("R5", "step progress", 32'(lim < 5000), 32'd1);
  endtask

  task automatic run_program(input int w);
    @(negedge clk);
    rst = 1'b1;
    wait_n = w;
    load_program();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1", "strobes during reset", {30'b0, bus_rd, bus_wr}, 32'd0);
      chk("R1", "step during reset", 32'(step), 32'd0);
    end
    rst = 1'b0;
    wait_steps(4);
    chk("R1", "first read after reset", rd_log[0], BASE);
    chk("R2", "fetch of load step", rd_log[1], 32'h104);
    chk("R2", "data read follows fetch", rd_log[2], 32'h200);
    chk("R2", "store step has no data read", rd_log[3], 32'h108);
    chk("R2", "plain step fetch", rd_log[4], 32'h10C);
    chk("R6", "core saw loaded word", acc, 32'hCAFE_1234);
    chk("R7", "memory written", mem[129], 32'hCAFE_1234);
    chk("R7", "write address", wr_addr_log, 32'h204);
    chk("R7", "write data", wr_data_log, 32'hCAFE_1234);
    chk("R7", "byte enables", {28'b0, wr_be_log}, 32'hF);
    chk("R2", "one write only", 32'(nwr), 32'd1);
    chk("R5", "load step length", 32'(step_at[1] - step_at[0]), 32'(2 * w + 5));
    chk("R5", "store step length", 32'(step_at[2] - step_at[1]), 32'(2 * w + 4));
    chk("R5", "plain step length", 32'(step_at[3] - step_at[2]), 32'(w + 3));
  endtask

  task automatic status_pass();
    @(negedge clk);
    st_active = 1'b1;
    st_result = 32'h1357_9BDF;
    #1;
    chk("R9", "active forwarded", 32'(active_out), 32'd1);
    chk("R9", "result forwarded", result_out, 32'h1357_9BDF);
    st_active = 1'b0;
    st_result = 32'hFFFF_0000;
    #1;
    chk("R9", "inactive forwarded", 32'(active_out), 32'd0);
    chk("R9", "result changed", result_out, 32'hFFFF_0000);
  endtask

  task automatic reset_midway();
    @(negedge clk);
    rst = 1'b1;
    wait_n = 4;
    load_program();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3", "fetch held while stalled", {30'b0, bus_rd, bus_wait}, 32'd3);
    rst = 1'b1;
    #1;
    chk("R10", "strobe dropped in reset cycle", 32'(bus_rd), 32'd0);
    wait_n = 0;
    @(negedge clk);
    chk("R10", "still quiet", {30'b0, bus_rd, bus_wr}, 32'd0);
    rst = 1'b0;
    wait_steps(2);
    chk("R10", "restart with fetch", rd_log[0], BASE);
    chk("R10", "load after restart", acc, 32'hCAFE_1234);
  endtask

  task automatic monitor_totals();
    chk("R1", "strobes seen in reset", 32'(bad_reset), 32'd0);
    chk("R3", "stalled request changed", 32'(bad_hold), 32'd0);
    chk("R8", "read and write together", 32'(bad_both), 32'd0);
    chk("R5", "step in consecutive cycles", 32'(bad_step2), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    run_program(0);
    run_program(3);
    run_program(1);
    status_pass();
    reset_midway();
    monitor_totals();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule